// File: doc/BRIEF.md
# MDIO Management Master

This block runs clause-22 management transactions between an Ethernet MAC and its PHYs. Software composes the whole 32-bit frame (start, opcode, PHY address, register address, turnaround, data) in one command word. Writing that word starts the transaction. The block generates MDC from the system clock and shifts the word onto MDIO, optionally after a run of ones as preamble. On a read it hands the line over to the PHY and captures the returned data into the low half of the same word.

A small control register sets the MDC divider and enables the preamble. A status register reports a busy bit and a sticky completion flag, which is also driven on the `irq` pin. Software clears the flag with a write-one before it issues the next command. A command written while a frame is in flight is dropped.

Top module: `mdio_master`

## Requirements
- R1: A command write to offset 1 starts a frame. If the preamble bit (control bit 7) is set, 32 ones go out first. The command word then goes out from bit 31 down to bit 0. With the preamble bit clear, no ones precede bit 31.
- R2: MDC stays high for (D+1) system clocks and then low for (D+1) system clocks, where D is control bits 6:0. A D of 0 behaves as 1. The frame ends, and `irq` rises, exactly 2·(D+1) clocks times the number of bits sent after the command write. MDC is low whenever no frame runs.
- R3: A frame is a read when command bits 29:28 equal binary 10. During a read, `mdio_oe` is low from bit 16 (the second turnaround bit) through bit 0. Outside those bits `mdio_oe` is high, and when idle `mdio_oe` is high with `mdio_o` at 1.
- R4: On a read, MDIO is sampled on each MDC rising edge of bits 15 to 0, and the samples replace command bits 15:0. Bits 31:16 read back unchanged.
- R5: After a write frame, offset 1 reads back the command word unchanged.
- R6: Status register (offset 2) bit 1 reads 1 while a frame is in progress and 0 otherwise.
- R7: A write to offset 1 while busy is ignored. The running frame and the stored command are unaffected.
- R8: Frame completion sets status bit 0, which `irq` mirrors. The flag stays set until a write to offset 2 with bit 0 at 1. A write with bit 0 at 0 leaves it set.
- R9: After reset all registers read 0, MDC is low, `irq` is low and `mdio_oe` is high.
- R10: Offset 0 reads back the control value written: divider in bits 6:0 and preamble enable in bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 command, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Sticky completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line value as seen at the pad |

## Verification
The bound checker holds on every cycle that MDC is parked low and toggles only inside a frame, that MDIO is released only during a frame, and that the completion flag rises only as busy falls and then stays until a write-one clears it. Frame content, bit order and preamble length, MDC half-period length and total frame duration can only be shown by the bench's scenarios. The same holds for read-data capture, the exact turnaround release point and the dropping of a mid-frame command. A PHY responder collects every MDC-sampled bit and compares it with the expected frame queued by the driver.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_W    = 32;
    localparam int DIV_W    = 7;
    localparam int PRE_LEN  = 32;
    localparam int ADDR_W   = 2;
    localparam int RDATA_W  = 16;
    localparam int POS_W    = $clog2(CMD_W);
    localparam int PRE_W    = $clog2(PRE_LEN + 1);
    localparam int REL_POS  = CMD_W - RDATA_W - 1;   // frame slot of second turnaround bit
    localparam int OP_HI    = CMD_W - 3;             // op field msb
    localparam int OP_LO    = CMD_W - 4;             // op field lsb

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_CMD  = 2'd1,
        SEL_STAT = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    function automatic logic [DIV_W:0] half_len(input logic [DIV_W-1:0] d);
        logic [DIV_W:0] h;
        if (d == '0) h = (DIV_W+1)'(2);
        else         h = {1'b0, d} + (DIV_W+1)'(1);
        return h;
    endfunction

    function automatic logic cmd_is_read(input logic [CMD_W-1:0] c);
        return c[OP_HI:OP_LO] == 2'b10;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             fall_stb
);
    logic [DIV_W:0] cnt;
    logic [DIV_W:0] half;
    logic           wrap;

    always_comb begin
        half = half_len(div);
        wrap = (cnt >= half - (DIV_W+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + (DIV_W+1)'(1);
        end
    end

    assign rise_stb = run && wrap && !mdc;
    assign fall_stb = run && wrap &&  mdc;
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CMD_W-1:0] load_word,
    input  logic             pre_en,
    input  logic             rise_stb,
    input  logic             fall_stb,
    input  logic             mdio_i,
    output logic             busy,
    output logic             done_stb,
    output logic [CMD_W-1:0] frame_word,
    output logic             mdio_o,
    output logic             mdio_oe
);
    logic [PRE_W-1:0] pre_left;
    logic [POS_W-1:0] pos;
    logic             is_rd;
    logic [POS_W-1:0] bit_idx;
    logic             in_pre;

    always_comb begin
        bit_idx  = ~pos;                               // CMD_W-1 - pos
        in_pre   = (pre_left != '0);
        done_stb = busy && fall_stb && !in_pre && (pos == POS_W'(CMD_W-1));
        mdio_o   = busy ? (in_pre ? 1'b1 : frame_word[bit_idx]) : 1'b1;
        mdio_oe  = !(busy && !in_pre && is_rd && (pos >= POS_W'(REL_POS)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            pre_left   <= '0;
            pos        <= '0;
            is_rd      <= 1'b0;
            frame_word <= '0;
        end else if (!busy) begin
            if (load) begin
                busy       <= 1'b1;
                frame_word <= load_word;
                pre_left   <= pre_en ? PRE_W'(PRE_LEN) : '0;
                pos        <= '0;
                is_rd      <= cmd_is_read(load_word);
            end
        end else begin
            if (rise_stb && !in_pre && is_rd && (pos > POS_W'(REL_POS)))
                frame_word[bit_idx] <= mdio_i;
            if (fall_stb) begin
                if (in_pre)
                    pre_left <= pre_left - PRE_W'(1);
                else if (pos == POS_W'(CMD_W-1))
                    busy <= 1'b0;
                else
                    pos <= pos + POS_W'(1);
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    input  logic              busy,
    input  logic              done_stb,
    input  logic [CMD_W-1:0]  frame_word,
    output ctrl_t             ctrl,
    output logic              cmd_load,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int CTRL_W = $bits(ctrl_t);

    logic done_flag;

    assign cmd_load = reg_wr && (reg_addr == SEL_CMD);
    assign irq      = done_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            done_flag <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == SEL_CTRL)
                ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
            if (done_stb)
                done_flag <= 1'b1;
            else if (reg_wr && reg_addr == SEL_STAT && reg_wdata[0])
                done_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            SEL_CTRL: reg_rdata = {{(CMD_W-CTRL_W){1'b0}}, ctrl};
            SEL_CMD:  reg_rdata = frame_word;
            SEL_STAT: reg_rdata = {{(CMD_W-2){1'b0}}, busy, done_flag};
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CMD_W-1:0]  reg_wdata,
    output logic [CMD_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    ctrl_t            ctrl;
    logic             cmd_load;
    logic             busy;
    logic             done_stb;
    logic [CMD_W-1:0] frame_word;
    logic             rise_stb;
    logic             fall_stb;

    mdio_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .busy(busy), .done_stb(done_stb),
        .frame_word(frame_word), .ctrl(ctrl), .cmd_load(cmd_load),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    mdio_clkgen u_clk (
        .clk(clk), .rst(rst), .run(busy), .div(ctrl.div),
        .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    mdio_shifter u_shf (
        .clk(clk), .rst(rst), .load(cmd_load), .load_word(reg_wdata),
        .pre_en(ctrl.pre_en), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .mdio_i(mdio_i), .busy(busy), .done_stb(done_stb),
        .frame_word(frame_word), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        irq,
    input logic        busy,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata
);
    // R2
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    // R2
    mdc_run_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> busy);

    // R3
    oe_release_chk: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe |-> busy);

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> irq);

    // R8
    irq_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $fell(busy));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_oe(mdio_oe), .irq(irq),
    .busy(busy), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b0;
    logic        phy_val = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        logic [31:0] cmd;
        bit          pre;
        logic [15:0] pat;
    } frame_item_t;

    frame_item_t exp_q[$];
    event go;

    always #10 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (phy_drv ? phy_val : 1'b1);

    mdio_master uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic start_cmd(input logic [31:0] c, input bit pre, input logic [15:0] pat);
        frame_item_t it;
        it.cmd = c; it.pre = pre; it.pat = pat;
        exp_q.push_back(it);
        reg_write(2'd1, c);
        -> go;
    endtask

    task automatic wait_irq(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            cyc++;
            #1;
        end while (!irq && cyc < 20000);
    endtask

    // PHY responder and scoreboard monitor
    initial begin
        forever begin
            frame_item_t it;
            logic [31:0] cap, expw;
            bit pre_ok, oe_ok, rd;
            int nb;
            @(go);
            it = exp_q.pop_front();
            nb = it.pre ? 64 : 32;
            rd = (it.cmd[29:28] == 2'b10);
            cap = '0; pre_ok = 1; oe_ok = 1;
            for (int i = 0; i < nb; i++) begin
                int p;
                @(posedge mdc);
                p = i - (nb - 32);
                if (p < 0) begin
                    if (mdio_i !== 1'b1 || mdio_oe !== 1'b1) pre_ok = 0;
                end else begin
                    cap[31-p] = mdio_i;
                    if (mdio_oe !== !(rd && p >= 15)) oe_ok = 0;
                    if (rd && p >= 14 && p < 31) begin
                        @(negedge mdc);
                        phy_drv = 1'b1;
                        phy_val = (p + 1 == 15) ? 1'b0 : it.pat[30-p];
                    end else if (rd && p == 31) begin
                        @(negedge mdc);
                        phy_drv = 1'b0;
                    end
                end
            end
            expw = rd ? {it.cmd[31:16], it.pat} : it.cmd;
            // R1: bit order and preamble on the wire
            check(pre_ok && cap == expw, "R1 frame bits", cap, expw);
            // R3: output-enable release window
            check(oe_ok, "R3 mdio_oe window", {31'b0, oe_ok}, 32'd1);
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] cw, cr, cr2, cb;
        int cyc, hp;
        cw  = {4'h5, 5'd3, 5'd4, 2'b10, 16'hA5C3};
        cr  = {4'h6, 5'd1, 5'd2, 2'b10, 16'h0000};
        cr2 = {4'h6, 5'd31, 5'd17, 2'b10, 16'hFFFF};
        cb  = {4'h5, 5'd9, 5'd9, 2'b10, 16'h1234};

        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9 reset state
        reg_read(2'd0, d); check(d == 0, "R9 ctrl reset", d, 0);
        reg_read(2'd1, d); check(d == 0, "R9 cmd reset", d, 0);
        reg_read(2'd2, d); check(d == 0, "R9 status reset", d, 0);
        check(!mdc && !irq && mdio_oe && mdio_o, "R9 pins idle",
              {28'b0, mdc, irq, mdio_oe, mdio_o}, 32'h3);

        // R10 control readback
        reg_write(2'd0, 32'h9f);
        reg_read(2'd0, d); check(d == 32'h9f, "R10 ctrl readback", d, 32'h9f);

        // R1 R2 R5 write frame with preamble, divider 0x1f
        start_cmd(cw, 1, 16'h0);
        wait_irq(cyc);
        check(cyc == 64 * 2 * 32, "R2 frame duration pre div31", cyc, 64 * 2 * 32);
        reg_read(2'd1, d); check(d == cw, "R5 write cmd unchanged", d, cw);
        check(!mdc, "R2 mdc idle low", {31'b0, mdc}, 0);
        reg_read(2'd2, d); check(d == 32'h1, "R6 status after done", d, 32'h1);

        // R8 sticky flag
        reg_write(2'd2, 32'h0);
        check(irq, "R8 write 0 keeps flag", {31'b0, irq}, 1);
        reg_write(2'd2, 32'h1);
        check(!irq, "R8 write 1 clears flag", {31'b0, irq}, 0);

        // R2 R3 R4 read frame, no preamble, divider 0 (acts as 1)
        reg_write(2'd0, 32'h00);
        fork
            begin
                start_cmd(cr, 0, 16'h1E5B);
                wait_irq(cyc);
            end
            begin
                @(posedge mdc);
                hp = 0;
                do begin
                    @(posedge clk);
                    hp++;
                    #1;
                end while (mdc && hp < 100);
            end
        join
        check(hp == 2, "R2 half period div0", hp, 2);
        check(cyc == 32 * 2 * 2, "R2 frame duration nopre div0", cyc, 128);
        reg_read(2'd1, d);
        check(d == {cr[31:16], 16'h1E5B}, "R4 read data captured", d, {cr[31:16], 16'h1E5B});
        reg_write(2'd2, 32'h1);

        // R6 R7 busy and ignored command
        reg_write(2'd0, 32'h01);
        start_cmd(cw, 0, 16'h0);
        reg_read(2'd2, d); check(d == 32'h2, "R6 busy during frame", d, 32'h2);
        reg_write(2'd1, cb);
        reg_read(2'd1, d); check(d == cw, "R7 busy write ignored", d, cw);
        wait_irq(cyc);
        reg_read(2'd1, d); check(d == cw, "R7 cmd intact after frame", d, cw);
        reg_read(2'd2, d); check(d == 32'h1, "R6 busy clear after frame", d, 32'h1);
        reg_write(2'd2, 32'h1);

        // R1 R2 R4 read with preamble, divider 3
        reg_write(2'd0, 32'h83);
        start_cmd(cr2, 1, 16'h8001);
        wait_irq(cyc);
        check(cyc == 64 * 2 * 4, "R2 frame duration pre div3", cyc, 512);
        reg_read(2'd1, d);
        check(d == {cr2[31:16], 16'h8001}, "R4 read data with preamble", d, {cr2[31:16], 16'h8001});
        check(mdio_oe && mdio_o, "R3 idle drive after read", {30'b0, mdio_oe, mdio_o}, 32'h3);

        repeat (10) @(posedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule